// File: doc/BRIEF.md
# Accumulator Processor with Interrupt Cycle

A small single-accumulator processor with 16-bit words. It runs a multi-cycle sequencer through three phases: fetch, execute and an optional interrupt cycle. It works with one synchronous, word-addressed memory. A read issued in one cycle returns its data in the next cycle, and a write takes effect at the clock edge. Each instruction has two fields: a 4-bit operation code in bits 15:12 and a 12-bit word address in bits 11:0. The instruction set covers load, store, add and return-from-interrupt. Every other code runs as a no-op.

After an instruction completes, the sequencer samples the single interrupt request. If the request is high and interrupts are enabled, the processor enters the interrupt cycle. It writes the address of the next instruction to memory word 0x000, disables further interrupts, pulses the acknowledge output for one cycle and continues fetching at the handler address 0x001. The return instruction reloads the program counter from word 0x000 and enables interrupts again. A request that arrives while interrupts are disabled stays pending until they are enabled again.

Top module: `acc_cpu`

## Requirements
- R1: After reset the first instruction is fetched from address 0x100, the accumulator holds zero and interrupts are enabled.
- R2: Bits 15:12 of an instruction select the operation and bits 11:0 give the memory word it acts on.
- R3: Code 0x1 copies the addressed memory word into the accumulator.
- R4: Code 0x2 writes the accumulator into the addressed memory word. This is the only memory write an ordinary instruction makes.
- R5: Code 0x5 adds the addressed memory word to the accumulator and keeps the sum modulo 2^16.
- R6: Each fetch advances the program counter by one, so instructions run from consecutive addresses.
- R7: Codes other than 0x1, 0x2, 0x5 and 0xF leave the accumulator and memory unchanged, and execution goes on at the next address.
- R8: When the request is high and interrupts are enabled at the end of an instruction, the processor writes the next-instruction address to word 0x000. In that same write cycle it asserts the acknowledge output for exactly one cycle. The next fetch reads address 0x001.
- R9: Taking an interrupt disables interrupts. While they are disabled, a held request is not acknowledged and stays pending.
- R10: Code 0xF loads the program counter from bits 11:0 of word 0x000 and enables interrupts. Its own address field is ignored. A request still pending is taken only after at least one instruction of the interrupted program has run.
- R11: Read enable and write enable are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| mem_addr | output | 12 | Word address for memory read or write |
| mem_wdata | output | 16 | Data to write |
| mem_rdata | input | 16 | Read data, valid the cycle after a read request |
| mem_re | output | 1 | Read request |
| mem_we | output | 1 | Write request |
| irq | input | 1 | Interrupt request, level sensitive |
| irq_ack | output | 1 | One-cycle pulse when an interrupt is taken |

## Verification
The bench uses the default parameters: 16-bit data, 12-bit addresses, reset address 0x100, save word 0x000 and handler at 0x001. Its memory model covers the full 4K-word space. At these values a program can reach operands at 0x940 and above, the wrap-around of the 16-bit sum, and the interaction between the save word, the handler area and the reset start address. With the request held high for a whole run, the bench shows that only one interrupted instruction runs between successive interrupt entries.

// File: rtl/acc_cpu_pkg.sv
// Shared types for the accumulator processor.
// Assumes a 4-bit operation field at the top of each instruction word.
package acc_cpu_pkg;

    typedef enum logic [3:0] {
        ST_FETCH,   // MAR <- PC
        ST_FREQ,    // read request at MAR
        ST_FCAP,    // MBR <- memory
        ST_DECODE,  // IR <- MBR, PC + 1
        ST_EADDR,   // MAR <- operand address, dispatch
        ST_OREQ,    // operand read request
        ST_OCAP,    // MBR <- operand
        ST_EXEC,    // update AC / PC / IE
        ST_SPREP,   // MBR <- AC
        ST_SWR,     // write MBR to MAR
        ST_ISAVE,   // MAR <- save word, MBR <- PC
        ST_IWR      // write return address, vector, disable
    } cpu_state_e;

    localparam logic [3:0] OP_LOAD  = 4'h1;
    localparam logic [3:0] OP_STORE = 4'h2;
    localparam logic [3:0] OP_ADD   = 4'h5;
    localparam logic [3:0] OP_RETI  = 4'hF;

    typedef struct packed {
        logic mar_from_pc;
        logic mar_from_ir;
        logic mar_from_save;
        logic mbr_from_mem;
        logic mbr_from_ac;
        logic mbr_from_pc;
        logic ir_from_mbr;
        logic pc_inc;
        logic pc_vector;
        logic pc_from_mbr;
        logic ac_load;
        logic ac_add;
        logic ie_clear;
        logic ie_set;
        logic rd;
        logic wr;
    } cpu_ctrl_t;

endpackage

// File: rtl/acc_cpu_alu.sv
// Accumulator adder: sum of two words, carry discarded (modulo 2^W).
// Assumes both operands are of equal width.
module acc_cpu_alu #(
    parameter int W = 16
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] sum
);
    // Wrapping addition.
    always_comb sum = a + b;
endmodule

// File: rtl/acc_cpu_seq.sv
// Multi-cycle sequencer: fetch, operand access, execute and interrupt cycle.
// Assumes memory returns read data one cycle after a read request.
module acc_cpu_seq
    import acc_cpu_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [3:0] ir_op,
    input  logic       irq,
    input  logic       ie,
    output cpu_ctrl_t  ctrl,
    output logic       irq_ack
);
    cpu_state_e state_q, state_d;
    logic       take_int;

    // Interrupt is taken only when enabled and requested.
    always_comb take_int = irq && ie;

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_FETCH;
        else        state_q <= state_d;
    end

    // Next state and control decode.
    always_comb begin
        ctrl    = '0;
        irq_ack = 1'b0;
        state_d = state_q;
        case (state_q)
            ST_FETCH: begin
                ctrl.mar_from_pc = 1'b1;
                state_d = ST_FREQ;
            end
            ST_FREQ: begin
                ctrl.rd = 1'b1;
                state_d = ST_FCAP;
            end
            ST_FCAP: begin
                ctrl.mbr_from_mem = 1'b1;
                state_d = ST_DECODE;
            end
            ST_DECODE: begin
                ctrl.ir_from_mbr = 1'b1;
                ctrl.pc_inc      = 1'b1;
                state_d = ST_EADDR;
            end
            ST_EADDR: begin
                case (ir_op)
                    OP_LOAD, OP_ADD: begin
                        ctrl.mar_from_ir = 1'b1;
                        state_d = ST_OREQ;
                    end
                    OP_RETI: begin
                        ctrl.mar_from_save = 1'b1;
                        state_d = ST_OREQ;
                    end
                    OP_STORE: begin
                        ctrl.mar_from_ir = 1'b1;
                        state_d = ST_SPREP;
                    end
                    default: state_d = ST_EXEC;
                endcase
            end
            ST_OREQ: begin
                ctrl.rd = 1'b1;
                state_d = ST_OCAP;
            end
            ST_OCAP: begin
                ctrl.mbr_from_mem = 1'b1;
                state_d = ST_EXEC;
            end
            ST_EXEC: begin
                case (ir_op)
                    OP_LOAD: ctrl.ac_load = 1'b1;
                    OP_ADD:  ctrl.ac_add  = 1'b1;
                    OP_RETI: begin
                        ctrl.pc_from_mbr = 1'b1;
                        ctrl.ie_set      = 1'b1;
                    end
                    default: ;
                endcase
                state_d = take_int ? ST_ISAVE : ST_FETCH;
            end
            ST_SPREP: begin
                ctrl.mbr_from_ac = 1'b1;
                state_d = ST_SWR;
            end
            ST_SWR: begin
                ctrl.wr = 1'b1;
                state_d = take_int ? ST_ISAVE : ST_FETCH;
            end
            ST_ISAVE: begin
                ctrl.mar_from_save = 1'b1;
                ctrl.mbr_from_pc   = 1'b1;
                state_d = ST_IWR;
            end
            ST_IWR: begin
                ctrl.wr        = 1'b1;
                ctrl.pc_vector = 1'b1;
                ctrl.ie_clear  = 1'b1;
                irq_ack        = 1'b1;
                state_d = ST_FETCH;
            end
            default: state_d = ST_FETCH;
        endcase
    end

    // R9: with interrupts disabled, the end of an instruction returns to fetch.
    p_no_take_disabled_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == ST_EXEC || state_q == ST_SWR) && !ie) |=> (state_q == ST_FETCH));

endmodule

// File: rtl/acc_cpu_regs.sv
// Datapath registers PC, IR, AC, MAR, MBR and the interrupt-enable flag.
// Assumes at most one source select per register is active in a cycle.
module acc_cpu_regs
    import acc_cpu_pkg::*;
#(
    parameter int                DATA_W    = 16,
    parameter int                ADDR_W    = 12,
    parameter logic [ADDR_W-1:0] RESET_PC  = 12'h100,
    parameter logic [ADDR_W-1:0] SAVE_ADDR = 12'h000,
    parameter logic [ADDR_W-1:0] VEC_ADDR  = 12'h001
) (
    input  logic              clk,
    input  logic              rst_n,
    input  cpu_ctrl_t         ctrl,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    output logic [3:0]        ir_op,
    output logic              ie
);
    localparam int OPC_W = DATA_W - ADDR_W;

    logic [ADDR_W-1:0] pc_q, mar_q;
    logic [DATA_W-1:0] ir_q, ac_q, mbr_q, sum;
    logic              ie_q;

    acc_cpu_alu #(.W(DATA_W)) u_alu (
        .a  (ac_q),
        .b  (mbr_q),
        .sum(sum)
    );

    // Program counter: reset start, increment, vector or return.
    always_ff @(posedge clk) begin
        if (!rst_n)                pc_q <= RESET_PC;
        else if (ctrl.pc_vector)   pc_q <= VEC_ADDR;
        else if (ctrl.pc_from_mbr) pc_q <= mbr_q[ADDR_W-1:0];
        else if (ctrl.pc_inc)      pc_q <= pc_q + 1'b1;
    end

    // Memory address register.
    always_ff @(posedge clk) begin
        if (!rst_n)                  mar_q <= '0;
        else if (ctrl.mar_from_pc)   mar_q <= pc_q;
        else if (ctrl.mar_from_ir)   mar_q <= ir_q[ADDR_W-1:0];
        else if (ctrl.mar_from_save) mar_q <= SAVE_ADDR;
    end

    // Memory buffer register.
    always_ff @(posedge clk) begin
        if (!rst_n)                 mbr_q <= '0;
        else if (ctrl.mbr_from_mem) mbr_q <= mem_rdata;
        else if (ctrl.mbr_from_ac)  mbr_q <= ac_q;
        else if (ctrl.mbr_from_pc)  mbr_q <= DATA_W'(pc_q);
    end

    // Instruction register.
    always_ff @(posedge clk) begin
        if (!rst_n)                ir_q <= '0;
        else if (ctrl.ir_from_mbr) ir_q <= mbr_q;
    end

    // Accumulator.
    always_ff @(posedge clk) begin
        if (!rst_n)            ac_q <= '0;
        else if (ctrl.ac_load) ac_q <= mbr_q;
        else if (ctrl.ac_add)  ac_q <= sum;
    end

    // Interrupt enable flag, set out of reset.
    always_ff @(posedge clk) begin
        if (!rst_n)             ie_q <= 1'b1;
        else if (ctrl.ie_clear) ie_q <= 1'b0;
        else if (ctrl.ie_set)   ie_q <= 1'b1;
    end

    // Port and status outputs.
    always_comb begin
        mem_addr  = mar_q;
        mem_wdata = mbr_q;
        ir_op     = ir_q[DATA_W-1 -: OPC_W];
        ie        = ie_q;
    end

    // R9: the sequencer only disables interrupts that were enabled.
    p_take_when_enabled_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl.ie_clear |-> ie_q);

    // R8: the word saved during the interrupt write is the current PC.
    p_save_value_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl.ie_clear |-> (ctrl.wr && mbr_q == DATA_W'(pc_q)));

endmodule

// File: rtl/acc_cpu.sv
// Top of the accumulator processor: sequencer plus datapath.
// Assumes a synchronous memory with one-cycle read latency on the port.
module acc_cpu #(
    parameter int                DATA_W    = 16,
    parameter int                ADDR_W    = 12,
    parameter logic [ADDR_W-1:0] RESET_PC  = 12'h100,
    parameter logic [ADDR_W-1:0] SAVE_ADDR = 12'h000,
    parameter logic [ADDR_W-1:0] VEC_ADDR  = 12'h001
) (
    input  logic              clk,
    input  logic              rst_n,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              mem_re,
    output logic              mem_we,
    input  logic              irq,
    output logic              irq_ack
);
    import acc_cpu_pkg::*;

    cpu_ctrl_t  ctrl;
    logic [3:0] ir_op;
    logic       ie;

    acc_cpu_seq u_seq (
        .clk    (clk),
        .rst_n  (rst_n),
        .ir_op  (ir_op),
        .irq    (irq),
        .ie     (ie),
        .ctrl   (ctrl),
        .irq_ack(irq_ack)
    );

    acc_cpu_regs #(
        .DATA_W   (DATA_W),
        .ADDR_W   (ADDR_W),
        .RESET_PC (RESET_PC),
        .SAVE_ADDR(SAVE_ADDR),
        .VEC_ADDR (VEC_ADDR)
    ) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .ctrl     (ctrl),
        .mem_rdata(mem_rdata),
        .mem_addr (mem_addr),
        .mem_wdata(mem_wdata),
        .ir_op    (ir_op),
        .ie       (ie)
    );

    // Memory strobes come straight from the sequencer.
    always_comb begin
        mem_re = ctrl.rd;
        mem_we = ctrl.wr;
    end

    // R11: read and write never share a cycle.
    p_port_excl_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_re && mem_we));

    // R8: acknowledge coincides with the write of the save word.
    p_ack_save_r8: assert property (@(posedge clk) disable iff (!rst_n)
        irq_ack |-> (mem_we && mem_addr == SAVE_ADDR));

    // R8: acknowledge lasts one cycle.
    p_ack_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        irq_ack |=> !irq_ack);

    // R8: the fetch after an acknowledge reads the handler address.
    p_ack_vector_r8: assert property (@(posedge clk) disable iff (!rst_n)
        irq_ack |=> ##1 (mem_re && mem_addr == VEC_ADDR));

endmodule

// File: tb/acc_cpu_tb.sv
`timescale 1ns/1ps
module acc_cpu_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [11:0] mem_addr;
    logic [15:0] mem_wdata;
    logic [15:0] mem_rdata = '0;
    logic        mem_re, mem_we;
    logic        irq = 1'b0;
    logic        irq_ack;

    logic [15:0] mem [0:4095];

    int n_cmp = 0;
    int n_bad = 0;
    int cyc   = 0;

    // Monitor state.
    logic [11:0] first_fetch;
    logic        first_seen;
    int          ack_cnt, wr_cnt, both_cnt, long_ack;
    logic        ack_armed, ack_prev;
    logic [11:0] post_ack_addr;
    logic [15:0] save_log [0:7];
    int          save_n;

    acc_cpu u_dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .mem_addr (mem_addr),
        .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata),
        .mem_re   (mem_re),
        .mem_we   (mem_we),
        .irq      (irq),
        .irq_ack  (irq_ack)
    );

    always #4 clk = ~clk;

    // Synchronous memory model, one-cycle read latency.
    always @(posedge clk) begin
        if (mem_re) mem_rdata <= mem[mem_addr];
        if (mem_we) mem[mem_addr] <= mem_wdata;
    end

    // Port monitor, sampled away from the active edge.
    always @(negedge clk) begin
        cyc++;
        if (!rst_n) begin
            first_seen = 1'b0; first_fetch = '0;
            ack_cnt = 0; wr_cnt = 0; both_cnt = 0; long_ack = 0;
            ack_armed = 1'b0; ack_prev = 1'b0; post_ack_addr = '1; save_n = 0;
        end else begin
            if (mem_re && !first_seen) begin
                first_seen = 1'b1; first_fetch = mem_addr;
            end
            if (mem_re && mem_we) both_cnt++;
            if (mem_we) begin
                wr_cnt++;
                if (mem_addr == 12'h000 && save_n < 8) begin
                    save_log[save_n] = mem_wdata; save_n++;
                end
            end
            if (mem_re && ack_armed) begin
                post_ack_addr = mem_addr; ack_armed = 1'b0;
            end
            if (irq_ack) begin
                ack_cnt++; ack_armed = 1'b1;
                if (ack_prev) long_ack++;
            end
            ack_prev = irq_ack;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic start_prog();
        @(negedge clk);
        rst_n = 1'b0;
        for (int i = 0; i < 4096; i++) mem[i] = 16'h0000;
    endtask

    task automatic release_run(input int n);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (n) @(negedge clk);
    endtask

    // R1 R4: first fetch address and zero accumulator after reset.
    task automatic t_reset();
        start_prog();
        irq = 1'b0;
        mem[12'h100] = 16'h2200;
        mem[12'h200] = 16'hBEEF;
        release_run(40);
        chk("R1 first fetch", 32'(first_fetch), 32'h100);
        chk("R1 R4 AC zero stored", 32'(mem[12'h200]), 32'h0000);
    endtask

    // R2 R3 R5 R6 R4: load/add/store sequence plus wrap of the sum.
    task automatic t_program();
        start_prog();
        mem[12'h100] = 16'h1940;
        mem[12'h101] = 16'h5941;
        mem[12'h102] = 16'h2941;
        mem[12'h103] = 16'h1942;
        mem[12'h104] = 16'h5943;
        mem[12'h105] = 16'h2944;
        mem[12'h940] = 16'h0003;
        mem[12'h941] = 16'h0002;
        mem[12'h942] = 16'hFFFF;
        mem[12'h943] = 16'h0003;
        release_run(100);
        chk("R3 R5 R6 sum in 941", 32'(mem[12'h941]), 32'h0005);
        chk("R5 wrap sum in 944", 32'(mem[12'h944]), 32'h0002);
        chk("R2 operand 940 untouched", 32'(mem[12'h940]), 32'h0003);
        chk("R4 write count", 32'(wr_cnt), 32'd2);
    endtask

    // R7: undefined codes do nothing to AC or memory.
    task automatic t_nop();
        start_prog();
        mem[12'h100] = 16'h1300;
        mem[12'h101] = 16'h3300;
        mem[12'h102] = 16'h7300;
        mem[12'h103] = 16'h2301;
        mem[12'h300] = 16'h1234;
        release_run(80);
        chk("R7 AC kept through no-ops", 32'(mem[12'h301]), 32'h1234);
        chk("R7 no-op target unchanged", 32'(mem[12'h300]), 32'h1234);
        chk("R7 only store writes", 32'(wr_cnt), 32'd1);
    endtask

    // R8 R10 R1: single interrupt, taken after first instruction.
    task automatic t_irq_once();
        start_prog();
        irq = 1'b1;
        mem[12'h100] = 16'h1300;
        mem[12'h101] = 16'h5301;
        mem[12'h102] = 16'h2302;
        mem[12'h001] = 16'h2311;
        mem[12'h002] = 16'hF000;
        mem[12'h300] = 16'h0010;
        mem[12'h301] = 16'h0020;
        fork
            release_run(120);
            begin
                wait (rst_n && ack_cnt > 0);
                @(negedge clk);
                irq = 1'b0;
            end
        join
        chk("R1 R8 saved return", 32'(mem[12'h000]), 32'h0101);
        chk("R8 ack count", 32'(ack_cnt), 32'd1);
        chk("R8 ack width", 32'(long_ack), 32'd0);
        chk("R8 handler fetch", 32'(post_ack_addr), 32'h001);
        chk("R8 handler store", 32'(mem[12'h311]), 32'h0010);
        chk("R10 program resumed", 32'(mem[12'h302]), 32'h0030);
    endtask

    // R9 R10: request held high, one main instruction between entries.
    task automatic t_irq_held();
        start_prog();
        irq = 1'b1;
        mem[12'h100] = 16'h1300;
        mem[12'h101] = 16'h5301;
        mem[12'h102] = 16'h2302;
        mem[12'h001] = 16'h2311;
        mem[12'h002] = 16'hF000;
        mem[12'h300] = 16'h0010;
        mem[12'h301] = 16'h0020;
        release_run(150);
        irq = 1'b0;
        chk("R9 save 1", 32'(save_log[0]), 32'h0101);
        chk("R10 save 2", 32'(save_log[1]), 32'h0102);
        chk("R10 save 3", 32'(save_log[2]), 32'h0103);
        chk("R9 R10 program result", 32'(mem[12'h302]), 32'h0030);
        chk("R9 handler copy", 32'(mem[12'h311]), 32'h0030);
        chk("R11 no read with write", 32'(both_cnt), 32'd0);
    endtask

    // Watchdog.
    initial begin
        #(8 * 100000);
        n_cmp++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        t_reset();
        t_program();
        t_nop();
        t_irq_once();
        t_irq_held();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule